// File: doc/BRIEF.md
# Charger Input Switch Sequencer

This block decides when the input pass switch of a battery charger protector may close. It samples digital comparator flags: input present (above the lockout level), input overvoltage and die over-temperature. It also takes an active-low enable, a switch-allow level from the neighbouring current and battery protection blocks, and a fault-report level from those same blocks. All of these pass through two-flop synchronizers. The block produces a switch-on command, an active-low fault level with an output-enable that models the released (high-impedance) state, and a clear level that tells the neighbouring blocks to reset their retry counters.

A single tick-driven settle timer (one tick per microsecond in the target system) supplies both the power-on deglitch wait and the overvoltage recovery wait. Each wait is `SETTLE_TICKS` ticks long. An overvoltage opens the switch as soon as the synchronized flag arrives, with no timer involved. If the input is still overvoltage when the power-on wait ends, the block goes straight to protection and never closes the switch.

Top module: `supply_gate_seq`

## Requirements
- R1: While the synchronized input-present flag is low, `sw_on`=0, `fault_oe`=0 and `nbr_clr`=1, whatever the other inputs are. These outputs follow the input two clock edges after it changes. After reset, the outputs are `sw_on`=0, `fault_oe`=0 and `nbr_clr`=1.
- R2: After input-present rises (with enable low and no faults), the block counts ticks starting at the fourth clock edge after the change. `sw_on` rises one edge after the edge that samples the `SETTLE_TICKS`-th counted tick.
- R3: If input overvoltage is set when that wait ends, `sw_on` stays 0 and the fault is driven (`fault_oe`=1, `fault_n`=0) from the next edge on.
- R4: In normal operation, input overvoltage drops `sw_on` and drives the fault two clock edges after the flag rises.
- R5: After overvoltage clears, ticks are counted from the third edge after the change. The switch closes and the fault releases one edge after the `SETTLE_TICKS`-th counted tick. If the flag returns during the wait, the count starts again.
- R6: Over-temperature drops `sw_on` and drives the fault two edges after it rises. Both recover two edges after it clears, with no settle wait.
- R7: Enable high (`en_n`=1) gives `sw_on`=0, `fault_oe`=0 and `nbr_clr`=1 two edges after it rises, even while faults are present.
- R8: With enable low and the switch closed, the neighbours' fault report drives the fault while the switch stays closed. A low `sw_allow` opens the switch without driving the fault.
- R9: When enable returns low, the full settle wait runs again, with the same timing as R2.
- R10: `nbr_clr` is 1 until the edge on which the settle wait begins, and 0 in every enabled, powered state.
- R11: `fault_n` is always the inverse of `fault_oe`. A released fault line reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse (1 µs in the target system) |
| in_present | input | 1 | Input above lockout level (asynchronous) |
| in_ovp | input | 1 | Input overvoltage (asynchronous) |
| over_temp | input | 1 | Die over-temperature (asynchronous) |
| en_n | input | 1 | Active-low enable (asynchronous) |
| sw_allow | input | 1 | Current and battery blocks permit the switch to close |
| ext_fault | input | 1 | Current or battery block reports a fault |
| sw_on | output | 1 | Close the pass switch |
| fault_n | output | 1 | Active-low fault level |
| fault_oe | output | 1 | Fault line driven (0 = high impedance) |
| nbr_clr | output | 1 | Clear the neighbouring blocks' retry counters |

## Verification
The hardest situations to reach are those where the settle timer competes with the overvoltage flag. One is the input arriving already overvoltage, so that the power-on wait expires into protection. The other is the flag returning partway through a recovery wait, which must restart the count. The bench drives the tick itself, so it knows which edges carry a tick. From the edge of each input change it computes the exact edge on which the switch may close, places a must-still-be-off check one edge before it, and re-asserts overvoltage a few ticks into a recovery wait.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,  // input absent
    ST_DIS  = 3'd1,  // enable high
    ST_WAIT = 3'd2,  // power-on settle
    ST_RUN  = 3'd3,  // normal operation
    ST_OVP  = 3'd4   // overvoltage protection / recovery
  } sgs_state_e;

  localparam int FLAG_W   = 6;
  localparam int IDX_PRES = 0;
  localparam int IDX_EN_N = 1;
  localparam int IDX_OVP  = 2;
  localparam int IDX_HOT  = 3;
  localparam int IDX_ALW  = 4;
  localparam int IDX_EXT  = 5;
  // enable resets to "disabled", everything else to 0
  localparam logic [FLAG_W-1:0] FLAG_RST = 6'b00_0010;
endpackage

// File: rtl/sgs_sync.sv
module sgs_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    logic stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/sgs_timer.sv
module sgs_timer #(
  parameter int TICKS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (tick && !done)    cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/sgs_fsm.sv
module sgs_fsm
  import sgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pres,
  input  logic       dis,
  input  logic       ovp,
  input  logic       hot,
  input  logic       allow,
  input  logic       ext,
  input  logic       done,
  output sgs_state_e st,
  output logic       tmr_clr,
  output logic       sw_cmd,
  output logic       fault_act,
  output logic       clr_req
);
  sgs_state_e st_nx;
  logic gate;

  assign gate = pres && !dis;

  always_comb begin
    st_nx = st;
    if (!pres)     st_nx = ST_OFF;
    else if (dis)  st_nx = ST_DIS;
    else begin
      unique case (st)
        ST_OFF, ST_DIS: st_nx = ST_WAIT;
        ST_WAIT:        if (done) st_nx = ovp ? ST_OVP : ST_RUN;
        ST_RUN:         if (ovp) st_nx = ST_OVP;
        ST_OVP:         if (done && !ovp) st_nx = ST_RUN;
        default:        st_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= st_nx;
  end

  // timer counts only in the settle wait or a clear-flag recovery wait
  assign tmr_clr   = !((st == ST_WAIT) || (st == ST_OVP && !ovp));
  assign sw_cmd    = gate && (st == ST_RUN) && !ovp && !hot && allow;
  assign fault_act = gate && ((st == ST_OVP) ||
                              (st == ST_RUN && (ovp || hot || ext)));
  assign clr_req   = !gate || (st == ST_OFF) || (st == ST_DIS);
endmodule

// File: rtl/supply_gate_seq.sv
module supply_gate_seq
  import sgs_pkg::*;
#(
  parameter int SETTLE_TICKS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic in_present,
  input  logic in_ovp,
  input  logic over_temp,
  input  logic en_n,
  input  logic sw_allow,
  input  logic ext_fault,
  output logic sw_on,
  output logic fault_n,
  output logic fault_oe,
  output logic nbr_clr
);
  logic [FLAG_W-1:0] raw, syn;
  logic pres_s, en_s, ovp_s, hot_s, alw_s, ext_s;
  logic tmr_clr, tmr_done, fault_act;
  sgs_state_e st;

  always_comb begin
    raw           = '0;
    raw[IDX_PRES] = in_present;
    raw[IDX_EN_N] = en_n;
    raw[IDX_OVP]  = in_ovp;
    raw[IDX_HOT]  = over_temp;
    raw[IDX_ALW]  = sw_allow;
    raw[IDX_EXT]  = ext_fault;
  end

  sgs_sync #(.W(FLAG_W), .RST_VAL(FLAG_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign pres_s = syn[IDX_PRES];
  assign en_s   = syn[IDX_EN_N];
  assign ovp_s  = syn[IDX_OVP];
  assign hot_s  = syn[IDX_HOT];
  assign alw_s  = syn[IDX_ALW];
  assign ext_s  = syn[IDX_EXT];

  sgs_timer #(.TICKS(SETTLE_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(tmr_clr), .done(tmr_done)
  );

  sgs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pres(pres_s), .dis(en_s), .ovp(ovp_s), .hot(hot_s),
    .allow(alw_s), .ext(ext_s), .done(tmr_done),
    .st(st), .tmr_clr(tmr_clr), .sw_cmd(sw_on),
    .fault_act(fault_act), .clr_req(nbr_clr)
  );

  assign fault_oe = fault_act;
  assign fault_n  = !fault_act;
endmodule

// File: rtl/sgs_chk.sv
module sgs_chk
  import sgs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sw_on,
  input logic       fault_oe,
  input logic       fault_n,
  input logic       nbr_clr,
  input logic       pres_s,
  input logic       en_s,
  input logic       ovp_s,
  input logic       hot_s,
  input logic       tmr_done,
  input sgs_state_e st
);
  assert_absent_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_s |-> (!sw_on && !fault_oe && nbr_clr));

  assert_close_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_RUN) |-> $past(tmr_done));

  assert_ovp_at_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && tmr_done && ovp_s && pres_s && !en_s) |=> (fault_oe && !sw_on));

  assert_ovp_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_s |-> !sw_on);

  assert_hot_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |-> !sw_on);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |-> (!sw_on && !fault_oe && nbr_clr));

  assert_clr_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nbr_clr |-> (pres_s && !en_s));

  assert_fault_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n != fault_oe);
endmodule

bind supply_gate_seq sgs_chk u_sgs_chk (
  .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .fault_oe(fault_oe),
  .fault_n(fault_n), .nbr_clr(nbr_clr), .pres_s(pres_s), .en_s(en_s),
  .ovp_s(ovp_s), .hot_s(hot_s), .tmr_done(tmr_done), .st(st)
);

// File: tb/test_supply_gate_seq.sv
`timescale 1ns/1ps
module test_supply_gate_seq;
  localparam int N  = 16;  // settle ticks
  localparam int TP = 4;   // clocks per tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic in_present = 1'b0, in_ovp = 1'b0, over_temp = 1'b0;
  logic en_n = 1'b0, sw_allow = 1'b1, ext_fault = 1'b0;
  logic sw_on, fault_n, fault_oe, nbr_clr;

  int edge_n = 0;
  int errs = 0;
  int checks = 0;

  typedef struct {
    int    e;
    bit    sw;
    bit    oe;
    bit    clr;
    string tag;
  } exp_t;
  exp_t q[$];

  supply_gate_seq #(.SETTLE_TICKS(N)) i_supply_gate_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_present(in_present),
    .in_ovp(in_ovp), .over_temp(over_temp), .en_n(en_n),
    .sw_allow(sw_allow), .ext_fault(ext_fault), .sw_on(sw_on),
    .fault_n(fault_n), .fault_oe(fault_oe), .nbr_clr(nbr_clr)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) edge_n++;

  // tick is seen at edge m exactly when m % TP == 0
  always @(negedge clk) tick <= (((edge_n + 1) % TP) == 0);

  function automatic int close_edge(int first);
    int m = first;
    int c = 0;
    while (1) begin
      if (m % TP == 0) c++;
      if (c == N) return m + 1;
      m++;
    end
  endfunction

  task automatic expect_at(int e, bit sw, bit oe, bit clr, string tag);
    exp_t x;
    x.e = e; x.sw = sw; x.oe = oe; x.clr = clr; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare scoreboard items due on this edge
  always @(negedge clk) begin : mon
    exp_t x;
    while (q.size() > 0 && q[0].e <= edge_n) begin
      x = q.pop_front();
      checks++;
      if (x.e != edge_n || sw_on !== x.sw || fault_oe !== x.oe ||
          fault_n !== !x.oe || nbr_clr !== x.clr) begin
        errs++;
        $display("FAIL %s edge %0d (due %0d): got sw=%b oe=%b fn=%b clr=%b exp sw=%b oe=%b fn=%b clr=%b",
                 x.tag, edge_n, x.e, sw_on, fault_oe, fault_n, nbr_clr,
                 x.sw, x.oe, !x.oe, x.clr);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : driver
    int e;
    int m;
    idle(4);
    rst_n = 1'b1;
    e = edge_n;
    expect_at(e + 1, 0, 0, 1, "R1 reset");
    idle(3);

    // R2 / R10: power-on settle
    e = edge_n; in_present = 1'b1;
    m = close_edge(e + 4);
    expect_at(e + 2, 0, 0, 1, "R10 before wait");
    expect_at(e + 3, 0, 0, 0, "R10 wait entered");
    expect_at(m - 1, 0, 0, 0, "R2 still open");
    expect_at(m,     1, 0, 0, "R2 close edge");
    idle(m - e + 3);

    // R4: overvoltage in normal operation
    e = edge_n; in_ovp = 1'b1;
    expect_at(e + 1, 1, 0, 0, "R4 before sync");
    expect_at(e + 2, 0, 1, 0, "R4 opened");
    idle(10);
    // R5: clear, re-assert partway, clear again
    in_ovp = 1'b0;
    idle(5 * TP);
    e = edge_n; in_ovp = 1'b1;
    expect_at(e + 1, 0, 1, 0, "R5 no early close");
    idle(8);
    e = edge_n; in_ovp = 1'b0;
    m = close_edge(e + 3);
    expect_at(m - 1, 0, 1, 0, "R5 restart still open");
    expect_at(m,     1, 0, 0, "R5 recovered");
    idle(m - e + 3);

    // R6: over-temperature
    e = edge_n; over_temp = 1'b1;
    expect_at(e + 2, 0, 1, 0, "R6 hot opens");
    idle(6);
    e = edge_n; over_temp = 1'b0;
    expect_at(e + 1, 0, 1, 0, "R6 before sync");
    expect_at(e + 2, 1, 0, 0, "R6 recovers at once");
    idle(4);

    // R8: neighbour fault and allow
    e = edge_n; ext_fault = 1'b1;
    expect_at(e + 2, 1, 1, 0, "R8 ext fault keeps switch");
    idle(4);
    e = edge_n; sw_allow = 1'b0;
    expect_at(e + 2, 0, 1, 0, "R8 allow low with fault");
    idle(4);
    e = edge_n; ext_fault = 1'b0;
    expect_at(e + 2, 0, 0, 0, "R8 allow low no fault");
    idle(4);
    e = edge_n; sw_allow = 1'b1;
    expect_at(e + 2, 1, 0, 0, "R8 allow back");
    idle(4);

    // R7: disable with faults present
    e = edge_n; en_n = 1'b1; over_temp = 1'b1; in_ovp = 1'b1;
    expect_at(e + 1, 1, 0, 0, "R7 before sync");
    expect_at(e + 2, 0, 0, 1, "R7 disabled quiet");
    idle(10);
    expect_at(edge_n + 1, 0, 0, 1, "R7 still quiet");
    idle(2);
    over_temp = 1'b0; in_ovp = 1'b0;
    idle(4);
    // R9: re-enable runs full wait
    e = edge_n; en_n = 1'b0;
    m = close_edge(e + 4);
    expect_at(e + 2, 0, 0, 1, "R9 still disabled");
    expect_at(m - 1, 0, 0, 0, "R9 still open");
    expect_at(m,     1, 0, 0, "R9 close edge");
    idle(m - e + 3);

    // R1: absence overrides all faults and enable
    e = edge_n; in_present = 1'b0; in_ovp = 1'b1; over_temp = 1'b1; ext_fault = 1'b1;
    expect_at(e + 2, 0, 0, 1, "R1 absent override");
    idle(6);
    over_temp = 1'b0; ext_fault = 1'b0;
    idle(3);

    // R3: power on into overvoltage
    e = edge_n; in_present = 1'b1;
    m = close_edge(e + 4);
    expect_at(m - 1, 0, 0, 0, "R3 wait no fault");
    expect_at(m,     0, 1, 0, "R3 protection at expiry");
    expect_at(m + 6, 0, 1, 0, "R3 never closes");
    idle(m - e + 8);
    e = edge_n; in_ovp = 1'b0;
    m = close_edge(e + 3);
    expect_at(m, 1, 0, 0, "R5 recovery after power-on ovp");
    idle(m - e + 3);

    // R1: present drops during settle wait
    e = edge_n; in_present = 1'b0;
    expect_at(e + 2, 0, 0, 1, "R1 drop in run");
    idle(4);
    in_present = 1'b1;
    idle(10);
    e = edge_n; in_present = 1'b0;
    expect_at(e + 2, 0, 0, 1, "R1 drop in wait");
    idle(4);

    if (q.size() != 0) begin
      errs++; checks++;
      $display("FAIL scoreboard: got %0d pending exp 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule